// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution stage of a 32-bit core with variable operand widths. The surrounding pipeline has already fetched the operands. Each cycle it may present one operation: an operation code, an operand size, a source operand, a destination operand and an 8-bit literal. One clock later the block returns the value to be written back, together with the updated condition flags. The flags are extend (X), negative (N), zero (Z), overflow (V) and carry (C).

The flags are architectural state and are held inside the block. This lets the extended forms of add, subtract and negate chain across several words of a multiprecision number. The carry of each word feeds the next word through X. Z then reports whether the whole chain came out zero.

Byte and word operations affect only the low 8 or 16 bits of the destination. The upper bits are returned unchanged, and the flags are computed at the selected width.

Top module: `intAlu`

## Requirements
- R1: When `opValid` is high at a rising edge with a legal code, `resultOut`, `flagsOut` and `resValid` (high) take their new values at that edge. Without `opValid`, `resValid` is low and the result and flags hold. Reset clears all three.
- R2: For sized operations, `opSize` selects the width: 0 = byte, 1 = word, 2 or 3 = long. Bits above the width come from `dstOp`. N is the top bit at that width, and Z is set when the bits at that width are all zero.
- R3: Code 0 (data move) returns `srcOp` at the width, sets N and Z from it, clears V and C, and keeps X.
- R4: Code 1 (quick load) returns `quickLit` sign-extended to 32 bits, whatever the size. N and Z come from the 32-bit value, V and C are cleared, and X is kept.
- R5: Code 2 (add: dst+src) and code 5 (subtract: dst−src) write the carry or borrow out of the width to both C and X. V is set on signed overflow at the width.
- R6: Code 3 (quick add) and code 6 (quick subtract) use `quickLit[2:0]` as the second operand, with 0 standing for 8. Their flags follow the R5 rules.
- R7: Code 4 (dst+src+X) and code 7 (dst−src−X) include X. Z is cleared if the sized result is nonzero and is otherwise kept. C, X, V and N follow R5.
- R8: Code 8 returns 0−dst, and code 9 returns 0−dst−X. Both use the R5 flag rules, and code 9 uses the R7 rule for Z.
- R9: Code 10 (clear) zeroes the bits at the width, sets Z, clears N, V and C, and keeps X.
- R10: Code 11 copies `dstOp[7]` into bits 15:8 and keeps bits 7:0 and 31:16. N and Z come from the low word, V and C are cleared, and X is kept.
- R11: Code 12 exchanges `dstOp[31:16]` with `dstOp[15:0]`. N and Z come from the 32-bit result, V and C are cleared, and X is kept.
- R12: Code 13 (address move) returns the source, and code 14 returns dst + source. The source is the full `srcOp` when `opSize[1]` is set; otherwise it is `srcOp[15:0]` sign-extended. All flags stay unchanged.
- R13: Code 15 is reserved. It leaves the result and the flags untouched, and `resValid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code (see requirements) |
| opSize | input | 2 | 0 byte, 1 word, 2/3 long |
| srcOp | input | 32 | Source operand |
| dstOp | input | 32 | Destination operand |
| quickLit | input | 8 | Embedded literal for quick forms |
| resultOut | output | 32 | Value to write back |
| flagsOut | output | 5 | Flags {X,N,Z,V,C} |
| resValid | output | 1 | Result and flags updated by the last edge |

## Verification
Every result, every flag and `resValid` is due at the first rising edge after the operation is presented. No output has a later path.

The bench drives inputs on a falling edge and samples on the next falling edge, half a cycle after the edge that loads the registers. It then lowers `opValid` and samples again one cycle later to confirm that the outputs hold.

A reference model in the bench carries its own copy of the flags from operation to operation. The chained Z and X behaviour is therefore checked across sequences, not only one operation at a time.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int BYTE_W = 8;
  localparam int FLAG_W = 5;
  localparam int QLIT_W = 8;
  localparam int QSEL_W = 3;
  localparam int OP_W   = 4;
  localparam int SIZE_W = 2;

  // flag bit positions inside flagsOut
  localparam int FX = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  typedef enum logic [OP_W-1:0] {
    OP_MOVE = 4'd0, OP_QLOAD = 4'd1, OP_ADD = 4'd2, OP_ADDQ = 4'd3,
    OP_ADDX = 4'd4, OP_SUB = 4'd5, OP_SUBQ = 4'd6, OP_SUBX = 4'd7,
    OP_NEG = 4'd8, OP_NEGX = 4'd9, OP_CLR = 4'd10, OP_EXTW = 4'd11,
    OP_SWAP = 4'd12, OP_MOVEA = 4'd13, OP_ADDA = 4'd14, OP_RSVD = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    RS_PASS, RS_ARITH, RS_ZERO, RS_EXT, RS_SWAP, RS_ADDR, RS_QUICK
  } resSel_e;

  typedef enum logic [1:0] {FM_KEEP, FM_LOGIC, FM_ARITH, FM_CHAIN} flagMode_e;
  typedef enum logic [1:0] {B_SRC, B_QUICK, B_DST} bSel_e;

  typedef struct packed {
    logic              load;
    resSel_e           resSel;
    flagMode_e         flagMode;
    logic              aZero;
    bSel_e             bSel;
    logic              subtract;
    logic              useX;
    logic              addAccum;
    logic [SIZE_W-1:0] effSize;
  } aluStrobe_t;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [SIZE_W-1:0] opSize,
  output aluStrobe_t        strobe
);
  always_comb begin
    strobe          = '0;
    strobe.load     = opValid && (opCode != OP_RSVD);
    strobe.resSel   = RS_PASS;
    strobe.flagMode = FM_LOGIC;
    strobe.bSel     = B_SRC;
    strobe.effSize  = opSize;
    unique case (aluOp_e'(opCode))
      OP_MOVE:  strobe.resSel = RS_PASS;
      OP_QLOAD: begin strobe.resSel = RS_QUICK; strobe.effSize = 2'd2; end
      OP_ADD, OP_ADDQ, OP_ADDX, OP_SUB, OP_SUBQ, OP_SUBX: begin
        strobe.resSel   = RS_ARITH;
        strobe.subtract = (opCode == OP_SUB) || (opCode == OP_SUBQ) || (opCode == OP_SUBX);
        strobe.bSel     = ((opCode == OP_ADDQ) || (opCode == OP_SUBQ)) ? B_QUICK : B_SRC;
        strobe.useX     = (opCode == OP_ADDX) || (opCode == OP_SUBX);
        strobe.flagMode = strobe.useX ? FM_CHAIN : FM_ARITH;
      end
      OP_NEG, OP_NEGX: begin
        strobe.resSel   = RS_ARITH;
        strobe.subtract = 1'b1;
        strobe.aZero    = 1'b1;
        strobe.bSel     = B_DST;
        strobe.useX     = (opCode == OP_NEGX);
        strobe.flagMode = strobe.useX ? FM_CHAIN : FM_ARITH;
      end
      OP_CLR:   strobe.resSel = RS_ZERO;
      OP_EXTW:  begin strobe.resSel = RS_EXT;  strobe.effSize = 2'd1; end
      OP_SWAP:  begin strobe.resSel = RS_SWAP; strobe.effSize = 2'd2; end
      OP_MOVEA, OP_ADDA: begin
        strobe.resSel   = RS_ADDR;
        strobe.flagMode = FM_KEEP;
        strobe.addAccum = (opCode == OP_ADDA);
      end
      default:  strobe.flagMode = FM_KEEP;
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [QLIT_W-1:0] quickLit,
  output logic [DATA_W-1:0] resultOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              resValid
);
  logic [DATA_W-1:0] resultQ, widthMask, aOp, bOp, aM, bM, rawSized, arithRes, addrSrc, nextRes;
  logic [DATA_W:0]   sum;
  logic [FLAG_W-1:0] flagsQ, nextFlags;
  logic              validQ, carryOut, ovf, cin, topA, topB, topR;

  function automatic logic msbOf(input logic [DATA_W-1:0] x, input logic [SIZE_W-1:0] sz);
    case (sz)
      2'd0:    return x[BYTE_W-1];
      2'd1:    return x[HALF_W-1];
      default: return x[DATA_W-1];
    endcase
  endfunction

  always_comb begin
    case (strobe.effSize)
      2'd0:    widthMask = DATA_W'({BYTE_W{1'b1}});
      2'd1:    widthMask = DATA_W'({HALF_W{1'b1}});
      default: widthMask = '1;
    endcase
  end

  // operand selection and sized adder/subtractor
  always_comb begin
    aOp = strobe.aZero ? '0 : dstOp;
    case (strobe.bSel)
      B_QUICK: bOp = (quickLit[QSEL_W-1:0] == '0) ? DATA_W'(8) : DATA_W'(quickLit[QSEL_W-1:0]);
      B_DST:   bOp = dstOp;
      default: bOp = srcOp;
    endcase
    aM  = aOp & widthMask;
    bM  = bOp & widthMask;
    cin = strobe.useX & flagsQ[FX];
    if (strobe.subtract) sum = {1'b0, aM} - {1'b0, bM} - {{DATA_W{1'b0}}, cin};
    else                 sum = {1'b0, aM} + {1'b0, bM} + {{DATA_W{1'b0}}, cin};
    case (strobe.effSize)
      2'd0:    carryOut = sum[BYTE_W];
      2'd1:    carryOut = sum[HALF_W];
      default: carryOut = sum[DATA_W];
    endcase
    arithRes = sum[DATA_W-1:0] & widthMask;
    topA = msbOf(aM, strobe.effSize);
    topB = msbOf(bM, strobe.effSize);
    topR = msbOf(arithRes, strobe.effSize);
    ovf  = strobe.subtract ? ((topA != topB) && (topR != topA))
                           : ((topA == topB) && (topR != topA));
  end

  // result shaping
  always_comb begin
    addrSrc = opSizeLong(strobe.effSize) ? srcOp : {{HALF_W{srcOp[HALF_W-1]}}, srcOp[HALF_W-1:0]};
    case (strobe.resSel)
      RS_ARITH: rawSized = arithRes;
      RS_ZERO:  rawSized = '0;
      RS_EXT:   rawSized = DATA_W'({{BYTE_W{dstOp[BYTE_W-1]}}, dstOp[BYTE_W-1:0]});
      RS_SWAP:  rawSized = {dstOp[HALF_W-1:0], dstOp[DATA_W-1:HALF_W]};
      RS_QUICK: rawSized = {{(DATA_W-QLIT_W){quickLit[QLIT_W-1]}}, quickLit};
      default:  rawSized = srcOp & widthMask;
    endcase
    if (strobe.resSel == RS_ADDR)
      nextRes = strobe.addAccum ? (dstOp + addrSrc) : addrSrc;
    else
      nextRes = (dstOp & ~widthMask) | rawSized;
  end

  function automatic logic opSizeLong(input logic [SIZE_W-1:0] sz);
    return sz[1];
  endfunction

  // flag update by class
  always_comb begin
    nextFlags = flagsQ;
    case (strobe.flagMode)
      FM_LOGIC: begin
        nextFlags[FN] = msbOf(rawSized, strobe.effSize);
        nextFlags[FZ] = (rawSized == '0);
        nextFlags[FV] = 1'b0;
        nextFlags[FC] = 1'b0;
      end
      FM_ARITH, FM_CHAIN: begin
        nextFlags[FX] = carryOut;
        nextFlags[FC] = carryOut;
        nextFlags[FV] = ovf;
        nextFlags[FN] = topR;
        if (strobe.flagMode == FM_ARITH) nextFlags[FZ] = (arithRes == '0);
        else if (arithRes != '0)         nextFlags[FZ] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strobe.load;
      if (strobe.load) begin
        resultQ <= nextRes;
        flagsQ  <= nextFlags;
      end
    end
  end

  assign resultOut = resultQ;
  assign flagsOut  = flagsQ;
  assign resValid  = validQ;
endmodule

// File: rtl/intAlu.sv
module intAlu
  import aluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [SIZE_W-1:0] opSize,
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [QLIT_W-1:0] quickLit,
  output logic [DATA_W-1:0] resultOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              resValid
);
  aluStrobe_t strobe;

  aluCtrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .opSize  (opSize),
    .strobe  (strobe)
  );

  aluDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcOp     (srcOp),
    .dstOp     (dstOp),
    .quickLit  (quickLit),
    .resultOut (resultOut),
    .flagsOut  (flagsOut),
    .resValid  (resValid)
  );
endmodule

// File: rtl/intAluChk.sv
module intAluChk
  import aluPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opCode,
  input logic [SIZE_W-1:0] opSize,
  input logic [DATA_W-1:0] srcOp,
  input logic [DATA_W-1:0] dstOp,
  input logic [QLIT_W-1:0] quickLit,
  input logic [DATA_W-1:0] resultOut,
  input logic [FLAG_W-1:0] flagsOut,
  input logic              resValid
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode != OP_RSVD) |=> resValid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && $stable(resultOut) && $stable(flagsOut)));
  // R3
  move_clears_vc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_MOVE) |=> (!flagsOut[FV] && !flagsOut[FC]));
  // R4
  quick_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_QLOAD) |=>
      (resultOut == {{(DATA_W-QLIT_W){$past(quickLit[QLIT_W-1])}}, $past(quickLit)}));
  // R5
  x_equals_c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode inside {OP_ADD, OP_SUB, OP_ADDQ, OP_SUBQ, OP_ADDX, OP_SUBX, OP_NEG, OP_NEGX})
      |=> (flagsOut[FX] == flagsOut[FC]));
  // R7
  chain_zero_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode inside {OP_ADDX, OP_SUBX, OP_NEGX} && !flagsOut[FZ]) |=> !flagsOut[FZ]);
  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_CLR) |=>
      (flagsOut[FZ] && !flagsOut[FN] && !flagsOut[FV] && !flagsOut[FC] && $stable(flagsOut[FX])));
  // R11
  swap_halves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_SWAP) |=>
      (resultOut == {$past(dstOp[HALF_W-1:0]), $past(dstOp[DATA_W-1:HALF_W])}));
  // R12
  addr_flags_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode inside {OP_MOVEA, OP_ADDA}) |=> $stable(flagsOut));
  // R13
  reserved_noop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_RSVD) |=> (!resValid && $stable(resultOut) && $stable(flagsOut)));
  // R2
  byte_upper_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSize == 2'd0 && opCode inside {OP_MOVE, OP_ADD, OP_SUB, OP_CLR})
      |=> (resultOut[DATA_W-1:BYTE_W] == $past(dstOp[DATA_W-1:BYTE_W])));
endmodule

bind intAlu intAluChk u_chk (.*);

// File: tb/intAlu_tb.sv
`timescale 1ns/1ps
module intAlu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [1:0]  opSize = '0;
  logic [31:0] srcOp = '0, dstOp = '0;
  logic [7:0]  quickLit = '0;
  logic [31:0] resultOut;
  logic [4:0]  flagsOut;
  logic        resValid;

  int total = 0;
  int bad = 0;
  logic [4:0]  expFlags = '0;
  logic [31:0] expRes = '0;

  always #2.5 clk = ~clk;

  intAlu u_dut (.*);

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0: return "R3";   4'd1: return "R4";
      4'd2, 4'd5: return "R5";
      4'd3, 4'd6: return "R6";
      4'd4, 4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      4'd10: return "R9";  4'd11: return "R10";
      4'd12: return "R11";
      4'd13, 4'd14: return "R12";
      default: return "R13";
    endcase
  endfunction

  // reference model built from the requirements
  function automatic void refOp(input logic [3:0] op, input logic [1:0] sz,
      input logic [31:0] s, input logic [31:0] d, input logic [7:0] lit,
      input logic [4:0] fin, output logic [31:0] r, output logic [4:0] fo);
    int w;
    logic [63:0] m, a, b, t;
    logic x, n, z, v, c, cin, isSub, sa, sb, sr;
    logic [31:0] lo, av;
    {x, n, z, v, c} = fin;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    if (op == 4'd1 || op == 4'd12) w = 32;
    if (op == 4'd11) w = 16;
    m = (64'd1 << w) - 64'd1;
    r = d;
    lo = '0;
    if (op >= 4'd2 && op <= 4'd9) begin
      a = {32'd0, d} & m;
      b = {32'd0, s} & m;
      if (op == 4'd3 || op == 4'd6) b = (lit[2:0] == 3'd0) ? 64'd8 : {61'd0, lit[2:0]};
      if (op >= 4'd8) begin a = '0; b = {32'd0, d} & m; end
      isSub = (op >= 4'd5);
      cin = (op == 4'd4 || op == 4'd7 || op == 4'd9) ? x : 1'b0;
      t = isSub ? (a - b - {63'd0, cin}) : (a + b + {63'd0, cin});
      lo = t[31:0] & m[31:0];
      c = t[w]; x = c;
      sa = a[w-1]; sb = b[w-1]; sr = lo[w-1];
      v = isSub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
      n = sr;
      if (cin === 1'b1 || op == 4'd4 || op == 4'd7 || op == 4'd9) z = (lo == 0) ? z : 1'b0;
      else z = (lo == 0);
      r = (d & ~m[31:0]) | lo;
    end else if (op == 4'd13 || op == 4'd14) begin
      av = sz[1] ? s : {{16{s[15]}}, s[15:0]};
      r = (op == 4'd14) ? d + av : av;
    end else if (op != 4'd15) begin
      case (op)
        4'd0:  lo = s & m[31:0];
        4'd1:  lo = {{24{lit[7]}}, lit};
        4'd10: lo = '0;
        4'd11: lo = {16'd0, {8{d[7]}}, d[7:0]};
        default: lo = {d[15:0], d[31:16]};
      endcase
      n = lo[w-1]; z = (lo == 0); v = 1'b0; c = 1'b0;
      r = (d & ~m[31:0]) | lo;
    end
    fo = {x, n, z, v, c};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic [1:0] sz,
      input logic [31:0] s, input logic [31:0] d, input logic [7:0] lit);
    logic [31:0] r;
    logic [4:0] f;
    @(negedge clk);
    opValid = 1'b1; opCode = op; opSize = sz; srcOp = s; dstOp = d; quickLit = lit;
    if (op != 4'd15) begin
      refOp(op, sz, s, d, lit, expFlags, r, f);
    end else begin
      r = expRes; f = expFlags;
    end
    @(negedge clk);
    opValid = 1'b0;
    check(resValid == (op != 4'd15), (op == 4'd15) ? "R13" : "R1", "valid",
          {31'd0, resValid}, {31'd0, op != 4'd15});
    check(resultOut == r, tagOf(op), "result", resultOut, r);
    check(flagsOut == f, tagOf(op), "flags", {27'd0, flagsOut}, {27'd0, f});
    if (sz != 2'd2 && sz != 2'd3 && op inside {4'd0, 4'd2, 4'd5, 4'd10})
      check(resultOut[31:16] == d[31:16], "R2", "upper bits", resultOut, d);
    expRes = r; expFlags = f;
  endtask

  task automatic idleCheck();
    @(negedge clk);
    check(!resValid && resultOut == expRes && flagsOut == expFlags, "R1", "idle hold",
          resultOut, expRes);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    check(resultOut == 0 && flagsOut == 0 && !resValid, "R1", "reset state",
          resultOut, 32'd0);
    rstN = 1'b1;
    // directed corners
    runOp(4'd1, 2'd0, 32'h0, 32'h0, 8'hFD);                 // R4 quick load -3
    check(resultOut == 32'hFFFF_FFFD, "R4", "minus three", resultOut, 32'hFFFF_FFFD);
    runOp(4'd0, 2'd0, 32'h1234_5680, 32'hAABB_CCDD, 8'h0);  // R3 byte move negative
    runOp(4'd2, 2'd0, 32'h0000_0001, 32'h1111_117F, 8'h0);  // R5 byte overflow
    runOp(4'd2, 2'd2, 32'h0000_0001, 32'hFFFF_FFFF, 8'h0);  // R5 carry, zero
    runOp(4'd4, 2'd2, 32'h0, 32'h0, 8'h0);                  // R7 uses X, nonzero
    runOp(4'd10, 2'd1, 32'h0, 32'h5555_7777, 8'h0);         // R9 clear word
    runOp(4'd4, 2'd2, 32'h0, 32'h0, 8'h0);                  // R7 zero keeps Z
    runOp(4'd6, 2'd1, 32'h0, 32'h0000_0005, 8'h00);         // R6 literal 0 means 8
    runOp(4'd3, 2'd0, 32'h0, 32'h0000_00FE, 8'h03);         // R6 byte carry
    runOp(4'd8, 2'd0, 32'h0, 32'h0000_0080, 8'h0);          // R8 negate min byte
    runOp(4'd9, 2'd2, 32'h0, 32'h0000_0000, 8'h0);          // R8 extended negate
    runOp(4'd11, 2'd2, 32'h0, 32'hABCD_0081, 8'h0);         // R10 sign extend
    runOp(4'd12, 2'd2, 32'h0, 32'h8000_1234, 8'h0);         // R11 swap
    runOp(4'd13, 2'd1, 32'hFFFF_8000, 32'h0, 8'h0);         // R12 word source
    runOp(4'd14, 2'd2, 32'h0000_0010, 32'h0000_0FF0, 8'h0); // R12 long add
    runOp(4'd15, 2'd2, 32'hDEAD_BEEF, 32'h1, 8'h7);         // R13 reserved
    idleCheck();                                            // R1 hold
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      runOp(op, 2'($urandom_range(0, 3)), $urandom(), $urandom(), 8'($urandom()));
      if ($urandom_range(0, 7) == 0) idleCheck();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule